// File: doc/BRIEF.md
# Pulse-Mode Divided Clock Synchronizer

This block derives the slow clock enables of a converter from its fast sample-rate clock. It also lets an external synchronization strobe fix the phase of those enables. Several devices that receive the same strobe edge in the same fast-clock cycle end up with data-rate enables that fire in the same cycle.

The strobe is sampled on the fast clock. It is not sampled on any slower reference clock. It passes through a two-flop synchronizer and then a rising-edge detector. A detected edge loads the divide counter with zero and latches the divide ratio selected at that moment. The counter produces a one-cycle data-rate enable once every N fast cycles, where N is 1, 2, 4 or 8. A second counter advances on each data-rate enable and produces a reference-rate enable once every REF_DIV data periods.

The strobe may be a single pulse or a periodic signal no faster than the data rate. An edge that agrees with the running phase leaves both counters as they are. An edge that disagrees sets a sticky timing-error flag and realigns the counters. The first edge after reset always aligns the counters without raising an error.

Top module: `clkdiv_sync`

## Requirements
- R1: After reset, and until the first strobe rising edge has been detected, data_en, ref_en and sync_err are all 0.
- R2: When a strobe rising edge is first sampled at fast-clock edge k, the counter holds zero after edge k+2, and data_en is first high in the cycle after edge k+1+N.
- R3: Once aligned, data_en is high for exactly one cycle in every N cycles. N is set by div_sel: code 0 gives 1, code 1 gives 2, code 2 gives 4, code 3 gives 8.
- R4: ref_en is high only together with data_en, on every REF_DIV-th data_en. After alignment it first fires on the REF_DIV-th data_en, so its period is N*REF_DIV cycles.
- R5: A strobe edge that takes effect in the clock edge where the counter wraps to zero anyway (a periodic strobe in phase) leaves the data_en and ref_en timing unchanged and does not set sync_err.
- R6: A strobe edge that takes effect while aligned, at a nonzero counter phase, sets sync_err and realigns data_en with the latency of R2.
- R7: sync_err stays set through later strobe edges, whether in phase or not, and is cleared only by reset.
- R8: A change of div_sel has no effect on the data_en period until the next strobe edge. From that edge on, the new ratio applies.
- R9: A strobe held high for many cycles counts as one edge. It aligns once, and the period continues undisturbed while the strobe stays high.
- R10: The first alignment after reset never sets sync_err.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast | input | 1 | Fast sample-rate clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sync_in | input | 1 | External synchronization strobe, asynchronous to the block |
| div_sel | input | 2 | Divide ratio code: 0 gives 1, 1 gives 2, 2 gives 4, 3 gives 8 |
| data_en | output | 1 | Data-rate enable, one fast cycle wide |
| ref_en | output | 1 | Reference-rate enable, coincides with a data_en |
| sync_err | output | 1 | Sticky strobe timing-error flag |

## Verification
The hardest case to bring about is a strobe edge that lands exactly on the counter wrap. The edge detector adds two cycles of delay, so a periodic strobe must be launched two cycles before the data_en it should coincide with. The bench waits for an observed data_en, counts N-2 further cycles and only then raises the strobe. Launching one cycle later gives the out-of-phase case. The same approach places an in-phase strobe between two reference enables, which shows that the reference phase is left untouched.

// File: rtl/clkdiv_sync.sv
module clkdiv_sync #(
  parameter int REF_DIV = 4,
  localparam int REF_W = (REF_DIV > 1) ? $clog2(REF_DIV) : 1
) (
  input  logic       clk_fast,
  input  logic       rst_n,
  input  logic       sync_in,
  input  logic [1:0] div_sel,
  output logic       data_en,
  output logic       ref_en,
  output logic       sync_err
);

  logic             s_meta, s_sync, s_prev;
  logic             sync_rise;
  logic [1:0]       div_q;
  logic [2:0]       cnt;
  logic [2:0]       last;
  logic [REF_W-1:0] ref_cnt;
  logic             aligned;
  logic             err_q;
  logic             at_wrap, ref_last, keep_ref;

  always_ff @(posedge clk_fast or negedge rst_n) begin
    if (!rst_n) begin
      s_meta <= 1'b0;
      s_sync <= 1'b0;
      s_prev <= 1'b0;
    end else begin
      s_meta <= sync_in;
      s_sync <= s_meta;
      s_prev <= s_sync;
    end
  end

  assign sync_rise = s_sync & ~s_prev;
  assign last      = (3'd1 << div_q) - 3'd1;
  assign at_wrap   = (cnt == last);
  assign ref_last  = (ref_cnt == REF_W'(REF_DIV - 1));
  assign keep_ref  = aligned & at_wrap & (div_sel == div_q);

  always_ff @(posedge clk_fast or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      div_q   <= '0;
      ref_cnt <= '0;
      aligned <= 1'b0;
      err_q   <= 1'b0;
    end else if (sync_rise) begin
      cnt     <= '0;
      div_q   <= div_sel;
      aligned <= 1'b1;
      if (!keep_ref)     ref_cnt <= '0;
      else if (ref_last) ref_cnt <= '0;
      else               ref_cnt <= ref_cnt + 1'b1;
      if (aligned && !at_wrap) err_q <= 1'b1;
    end else if (aligned) begin
      cnt <= at_wrap ? 3'd0 : cnt + 3'd1;
      if (at_wrap) ref_cnt <= ref_last ? '0 : ref_cnt + 1'b1;
    end
  end

  assign data_en  = aligned & at_wrap;
  assign ref_en   = data_en & ref_last;
  assign sync_err = err_q;

endmodule

// File: rtl/clkdiv_sync_chk.sv
module clkdiv_sync_chk (
  input logic       clk_fast,
  input logic       rst_n,
  input logic       sync_in,
  input logic       data_en,
  input logic       ref_en,
  input logic       sync_err,
  input logic       sync_rise,
  input logic [2:0] cnt,
  input logic [1:0] div_q
);

  logic seen_sync;
  always_ff @(posedge clk_fast or negedge rst_n) begin
    if (!rst_n)       seen_sync <= 1'b0;
    else if (sync_in) seen_sync <= 1'b1;
  end

  p_quiet_before_sync_r1: assert property (@(posedge clk_fast) disable iff (!rst_n)
    data_en |-> seen_sync);

  p_cnt_in_range_r3: assert property (@(posedge clk_fast) disable iff (!rst_n)
    {1'b0, cnt} < (4'd1 << div_q));

  p_ref_with_data_r4: assert property (@(posedge clk_fast) disable iff (!rst_n)
    ref_en |-> data_en);

  p_err_from_edge_r6: assert property (@(posedge clk_fast) disable iff (!rst_n)
    $rose(sync_err) |-> $past(sync_rise));

  p_err_sticky_r7: assert property (@(posedge clk_fast) disable iff (!rst_n)
    sync_err |=> sync_err);

endmodule

bind clkdiv_sync clkdiv_sync_chk u_chk (.*);

// File: tb/clkdiv_sync_tb_top.sv
`timescale 1ns/1ps
module clkdiv_sync_tb_top;

  logic       clk_fast = 1'b0;
  logic       rst_n = 1'b0;
  logic       sync_in = 1'b0;
  logic [1:0] div_sel = 2'd0;
  logic       data_en, ref_en, sync_err;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  localparam int REFD = 4;

  always #5 clk_fast = ~clk_fast;

  clkdiv_sync #(.REF_DIV(REFD)) dut_i (
    .clk_fast(clk_fast), .rst_n(rst_n), .sync_in(sync_in), .div_sel(div_sel),
    .data_en(data_en), .ref_en(ref_en), .sync_err(sync_err));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic wait_en();
    for (int i = 0; i < 40; i++) begin
      @(negedge clk_fast);
      if (data_en) break;
    end
  endtask

  // R1: outputs quiet through reset and without a strobe
  task automatic t_reset();
    int seen = 0;
    sync_in = 1'b0;
    @(negedge clk_fast);
    rst_n = 1'b0;
    repeat (3) @(negedge clk_fast);
    chk({data_en, ref_en, sync_err} == 3'b000, "R1 reset outputs", {data_en, ref_en, sync_err}, 0);
    rst_n = 1'b1;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk_fast);
      if (data_en || ref_en || sync_err) seen++;
    end
    chk(seen == 0, "R1 quiet before strobe", seen, 0);
  endtask

  // R2/R6 latency: strobe launched now; enable expected at negedge n+2
  task automatic t_align(input int code, input int hold, input string req);
    int n = 1 << code;
    int early = 0;
    bit at_m1 = 1'b0, at_exp = 1'b0;
    div_sel = 2'(code);
    sync_in = 1'b1;
    for (int i = 1; i <= n + 2; i++) begin
      @(negedge clk_fast);
      if (i >= hold) sync_in = 1'b0;
      if (i <= n && data_en) early++;
      if (i == n + 1) at_m1 = data_en;
      if (i == n + 2) at_exp = data_en;
    end
    chk(at_exp, req, at_exp, 1);
    if (n >= 2) chk(!at_m1, req, at_m1, 0);
  endtask

  // R3: spacing between enables
  task automatic t_period(input int n, input string req);
    wait_en();
    for (int r = 0; r < 3; r++) begin
      int c = 0;
      do begin
        @(negedge clk_fast);
        c++;
      end while (!data_en && c < 20);
      chk(c == n, req, c, n);
    end
  endtask

  // R4: reference enable spacing and coincidence
  task automatic t_ref(input int n);
    int c = 0, bad = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk_fast);
      if (ref_en) break;
    end
    do begin
      @(negedge clk_fast);
      c++;
      if (ref_en && !data_en) bad++;
    end while (!ref_en && c < 200);
    chk(c == n * REFD, "R4 ref period", c, n * REFD);
    chk(bad == 0, "R4 ref with data", bad, 0);
  endtask

  // R5: in-phase strobe between two reference enables
  task automatic t_inphase(input int n);
    int c = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk_fast);
      if (ref_en) break;
    end
    repeat (n - 2) begin @(negedge clk_fast); c++; end
    sync_in = 1'b1;
    @(negedge clk_fast); c++;
    sync_in = 1'b0;
    while (!ref_en && c < 200) begin @(negedge clk_fast); c++; end
    chk(c == n * REFD, "R5 ref phase kept", c, n * REFD);
    chk(sync_err == 1'b0, "R5 no error", sync_err, 0);
  endtask

  // launch an in-phase strobe for current ratio n (n>=2), leave div_sel as set
  task automatic pulse_inphase(input int n);
    wait_en();
    repeat (n - 2) @(negedge clk_fast);
    sync_in = 1'b1;
    @(negedge clk_fast);
    sync_in = 1'b0;
  endtask

  initial begin
    #2_000_000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    t_reset();

    t_align(2, 1, "R2 first alignment latency");
    chk(sync_err == 1'b0, "R10 first alignment no error", sync_err, 0);
    t_period(4, "R3 period 4");
    t_ref(4);
    t_inphase(4);
    t_period(4, "R5 period after in-phase");

    div_sel = 2'd1;
    t_period(4, "R8 period holds before strobe");
    pulse_inphase(4);
    chk(sync_err == 1'b0, "R8 no error on ratio change", sync_err, 0);
    t_period(2, "R8 new period after strobe");

    wait_en();
    @(negedge clk_fast);
    t_align(1, 1, "R6 realign latency");
    chk(sync_err == 1'b1, "R6 error set", sync_err, 1);
    t_period(2, "R6 period after realign");

    pulse_inphase(2);
    repeat (6) @(negedge clk_fast);
    chk(sync_err == 1'b1, "R7 error sticky", sync_err, 1);
    t_reset();
    chk(sync_err == 1'b0, "R7 cleared by reset", sync_err, 0);

    t_align(0, 1, "R2 latency ratio 1");
    t_period(1, "R3 period 1");
    t_reset();
    t_align(3, 1, "R2 latency ratio 8");
    t_period(8, "R3 period 8");
    t_ref(8);

    t_reset();
    t_align(1, 40, "R9 level strobe latency");
    repeat (36) @(negedge clk_fast);
    sync_in = 1'b0;
    chk(sync_err == 1'b0, "R9 no error on level", sync_err, 0);
    t_period(2, "R9 period under level");

    finish_run();
  end

endmodule